// File: doc/BRIEF.md
# Coprocessor Two-Word Load/Store Sequencer

This block moves words between a 32-bit host data bus and one entry of a 64-bit coprocessor register file during load and store instructions. A start strobe captures the transfer: direction, one or two words, float or integer register view, and the target register index. The sequencer then consumes data beats from the bus. For a load, each beat becomes a write to one or both halves of the register. For a store, the selected half of the register is presented on the data-out bus for each beat.

A 64-bit register holds a 32-bit integer in its lower half and a single-precision float in its upper half. For two-word transfers, the endianness input decides which half each word maps to. It is sampled on every beat, not once per transfer. A 32-bit integer load sign-extends into all 64 bits. Bus beats marked as non-data pass by with no effect. A one-cycle done pulse closes each transfer. The register file itself sits outside the block and is reached through one combinational read port and one write port with per-half enables.

Top module: `coproc_xfer_seq`

## Requirements
- R1: While reset is held, and after its release until a transfer is started, doneOut is 0 and rfWrEn is 0, even when data beats are present.
- R2: Both rfWrIdx and rfRdIdx equal the regIdx value captured with the start strobe, and keep that value for the whole transfer even if regIdx changes afterwards.
- R3: A two-word load (storeSel=0, sizeDouble=1) with bigEnd=1 on both beats writes the first word to bits 63:32 and the second word to bits 31:0 of the register.
- R4: A two-word load with bigEnd=0 on both beats writes the first word to bits 31:0 and the second word to bits 63:32.
- R5: For each word of a two-word transfer, the half is chosen from the bigEnd value present on that beat: word k goes to the upper half when bigEnd XOR (k==1) is 1, and to the lower half otherwise.
- R6: A one-word float load (sizeDouble=0, intView=0) writes the beat into bits 63:32 and leaves bits 31:0 unchanged.
- R7: A one-word integer load (sizeDouble=0, intView=1) writes the beat into bits 31:0 and copies its bit 31 into all of bits 63:32.
- R8: During a two-word store (storeSel=1), dataOut shows the register half chosen by the rule of R5 for the current word, and the register is not written.
- R9: During a one-word store, dataOut shows bits 63:32 for the float view (intView=0) and bits 31:0 for the integer view (intView=1).
- R10: A beat with beatValid=1 and beatIsData=0 causes no write and does not advance the word count.
- R11: doneOut is high for exactly the one cycle after the clock edge that accepts the last word, and the word count then restarts, so the next transfer begins with its first word.
- R12: A start strobe during a transfer in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Starts a transfer when the sequencer is idle |
| regIdx | input | 4 | Register index of the transfer, captured at start |
| storeSel | input | 1 | 1 = store (register to bus), 0 = load |
| sizeDouble | input | 1 | 1 = two words, 0 = one word |
| intView | input | 1 | 1 = integer view, 0 = float view |
| bigEnd | input | 1 | Live endianness, 1 = big-endian |
| beatValid | input | 1 | A bus beat is present this cycle |
| beatIsData | input | 1 | The present beat carries data |
| dataIn | input | 32 | Load data from the bus |
| rfRdData | input | 64 | Read data of the register file for rfRdIdx |
| dataOut | output | 32 | Store data to the bus |
| rfRdIdx | output | 4 | Register file read index |
| rfWrEn | output | 1 | Register file write strobe |
| rfWrIdx | output | 4 | Register file write index |
| rfWrHiEn | output | 1 | Write bits 63:32 |
| rfWrLoEn | output | 1 | Write bits 31:0 |
| rfWrData | output | 64 | Register file write data |
| doneOut | output | 1 | One-cycle pulse after the last word |

## Verification
The bench targets these cases:
- Endianness flipped between the two beats of one transfer. A design that latches the endianness at start would then put both words in opposite halves, where the live rule sends both to the same half.
- Negative and positive one-word integer loads. A missing sign extension, or zero-filling, leaves a stale or zero upper half.
- Non-data beats placed inside transfers. A design that counts them would end early or write garbage.
- A second start and a changed index during a busy transfer. These expose a design that restarts or retargets mid-flight.
- A one-word transfer followed at once by a two-word one. This shows whether the word count was cleared at done.

// File: rtl/coproc_xfer_pkg.sv
package coproc_xfer_pkg;

  // Number of bus words in a two-word transfer.
  localparam int WordsPerDouble = 2;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic capture;  // latch transfer fields this cycle
    logic take;     // a data beat is consumed this cycle
    logic wordSel;  // 0 = first word, 1 = second word
    logic dbl;      // transfer in progress is two words
  } xferStrobe_t;

endpackage

// File: rtl/coproc_xfer_ctrl.sv
module coproc_xfer_ctrl
  import coproc_xfer_pkg::*;
#(
  parameter int MAX_WORDS = WordsPerDouble
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        sizeDouble,
  input  logic        beatValid,
  input  logic        beatIsData,
  output xferStrobe_t strobe,
  output logic        doneOut
);

  localparam int CntW = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
  localparam logic [CntW-1:0] LastIdx = CntW'(MAX_WORDS - 1);

  logic            busyQ;
  logic            dblQ;
  logic            doneQ;
  logic [CntW-1:0] wordCntQ;
  logic            capture;
  logic            take;
  logic            lastBeat;

  assign capture  = startIn & ~busyQ;
  assign take     = busyQ & beatValid & beatIsData;
  assign lastBeat = take & (~dblQ | (wordCntQ == LastIdx));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      dblQ     <= 1'b0;
      doneQ    <= 1'b0;
      wordCntQ <= '0;
    end else begin
      doneQ <= lastBeat;
      if (capture) begin
        busyQ    <= 1'b1;
        dblQ     <= sizeDouble;
        wordCntQ <= '0;
      end else if (lastBeat) begin
        busyQ    <= 1'b0;
        wordCntQ <= '0;
      end else if (take) begin
        wordCntQ <= wordCntQ + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.capture = capture;
    strobe.take    = take;
    strobe.wordSel = (wordCntQ != '0);
    strobe.dbl     = dblQ;
  end

  assign doneOut = doneQ;

endmodule

// File: rtl/coproc_xfer_datapath.sv
module coproc_xfer_datapath
  import coproc_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  xferStrobe_t         strobe,
  input  logic [IDX_W-1:0]    regIdx,
  input  logic                storeSel,
  input  logic                intView,
  input  logic                bigEnd,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [2*DATA_W-1:0] rfRdData,
  output logic [DATA_W-1:0]   dataOut,
  output logic [IDX_W-1:0]    rfRdIdx,
  output logic                rfWrEn,
  output logic [IDX_W-1:0]    rfWrIdx,
  output logic                rfWrHiEn,
  output logic                rfWrLoEn,
  output logic [2*DATA_W-1:0] rfWrData
);

  logic [IDX_W-1:0]  idxQ;
  logic              storeQ;
  logic              intQ;
  logic              useHi;
  logic [DATA_W-1:0] hiHalf;
  logic [DATA_W-1:0] loHalf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ   <= '0;
      storeQ <= 1'b0;
      intQ   <= 1'b0;
    end else if (strobe.capture) begin
      idxQ   <= regIdx;
      storeQ <= storeSel;
      intQ   <= intView;
    end
  end

  // Half selection: two-word transfers follow the live endianness,
  // one-word transfers follow the register view.
  always_comb begin
    if (strobe.dbl) useHi = bigEnd ^ strobe.wordSel;
    else            useHi = ~intQ;
  end

  assign hiHalf = rfRdData[2*DATA_W-1:DATA_W];
  assign loHalf = rfRdData[DATA_W-1:0];

  assign dataOut = useHi ? hiHalf : loHalf;
  assign rfRdIdx = idxQ;
  assign rfWrIdx = idxQ;

  always_comb begin
    rfWrEn   = strobe.take & ~storeQ;
    rfWrHiEn = 1'b0;
    rfWrLoEn = 1'b0;
    rfWrData = {dataIn, dataIn};
    if (rfWrEn) begin
      if (!strobe.dbl && intQ) begin
        rfWrHiEn = 1'b1;
        rfWrLoEn = 1'b1;
        rfWrData = {{DATA_W{dataIn[DATA_W-1]}}, dataIn};
      end else begin
        rfWrHiEn = useHi;
        rfWrLoEn = ~useHi;
      end
    end
  end

endmodule

// File: rtl/coproc_xfer_seq.sv
module coproc_xfer_seq
  import coproc_xfer_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 16,
  localparam int IDX_W    = $clog2(REG_COUNT),
  localparam int REG_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic              storeSel,
  input  logic              sizeDouble,
  input  logic              intView,
  input  logic              bigEnd,
  input  logic              beatValid,
  input  logic              beatIsData,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [REG_W-1:0]  rfRdData,
  output logic [DATA_W-1:0] dataOut,
  output logic [IDX_W-1:0]  rfRdIdx,
  output logic              rfWrEn,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic              rfWrHiEn,
  output logic              rfWrLoEn,
  output logic [REG_W-1:0]  rfWrData,
  output logic              doneOut
);

  xferStrobe_t strobe;

  coproc_xfer_ctrl #(
    .MAX_WORDS(WordsPerDouble)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .sizeDouble(sizeDouble),
    .beatValid (beatValid),
    .beatIsData(beatIsData),
    .strobe    (strobe),
    .doneOut   (doneOut)
  );

  coproc_xfer_datapath #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .regIdx  (regIdx),
    .storeSel(storeSel),
    .intView (intView),
    .bigEnd  (bigEnd),
    .dataIn  (dataIn),
    .rfRdData(rfRdData),
    .dataOut (dataOut),
    .rfRdIdx (rfRdIdx),
    .rfWrEn  (rfWrEn),
    .rfWrIdx (rfWrIdx),
    .rfWrHiEn(rfWrHiEn),
    .rfWrLoEn(rfWrLoEn),
    .rfWrData(rfWrData)
  );

endmodule

// File: rtl/coproc_xfer_chk.sv
module coproc_xfer_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                beatValid,
  input logic                beatIsData,
  input logic                rfWrEn,
  input logic                rfWrHiEn,
  input logic                rfWrLoEn,
  input logic [IDX_W-1:0]    rfWrIdx,
  input logic [IDX_W-1:0]    rfRdIdx,
  input logic [2*DATA_W-1:0] rfWrData,
  input logic                doneOut
);

  // R10: a write needs a data beat on the bus.
  a_r10_write_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (beatValid && beatIsData));

  // R11: done lasts a single cycle.
  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R11: no write is issued in the done cycle.
  a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !rfWrEn);

  // R7: a write covering both halves carries a sign-extended word.
  a_r7_sign_extend: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && rfWrHiEn && rfWrLoEn) |->
      (rfWrData[2*DATA_W-1:DATA_W] == {DATA_W{rfWrData[DATA_W-1]}}));

  // R3: every write targets at least one half.
  a_r3_half_selected: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (rfWrHiEn || rfWrLoEn));

  // R2: the write index holds steady across the words of a transfer.
  a_r2_index_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && !doneOut) |=> (!rfWrEn || (rfWrIdx == $past(rfWrIdx))));

  // R2: read and write ports address the same register.
  a_r2_ports_agree: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (rfWrIdx == rfRdIdx));

endmodule

bind coproc_xfer_seq coproc_xfer_chk #(
  .DATA_W(DATA_W),
  .IDX_W (IDX_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .beatValid (beatValid),
  .beatIsData(beatIsData),
  .rfWrEn    (rfWrEn),
  .rfWrHiEn  (rfWrHiEn),
  .rfWrLoEn  (rfWrLoEn),
  .rfWrIdx   (rfWrIdx),
  .rfRdIdx   (rfRdIdx),
  .rfWrData  (rfWrData),
  .doneOut   (doneOut)
);

// File: tb/coproc_xfer_seq_tb_top.sv
module coproc_xfer_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        startIn;
  logic [3:0]  regIdx;
  logic        storeSel;
  logic        sizeDouble;
  logic        intView;
  logic        bigEnd;
  logic        beatValid;
  logic        beatIsData;
  logic [31:0] dataIn;
  logic [63:0] rfRdData;
  logic [31:0] dataOut;
  logic [3:0]  rfRdIdx;
  logic        rfWrEn;
  logic [3:0]  rfWrIdx;
  logic        rfWrHiEn;
  logic        rfWrLoEn;
  logic [63:0] rfWrData;
  logic        doneOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Register file model, also used by the bench to preload values.
  logic [63:0] rfModel [16];
  logic        pokeEn = 1'b0;
  logic [3:0]  pokeIdx = '0;
  logic [63:0] pokeVal = '0;

  always #4 clk = ~clk;

  coproc_xfer_seq dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .regIdx(regIdx),
    .storeSel(storeSel), .sizeDouble(sizeDouble), .intView(intView),
    .bigEnd(bigEnd), .beatValid(beatValid), .beatIsData(beatIsData),
    .dataIn(dataIn), .rfRdData(rfRdData), .dataOut(dataOut),
    .rfRdIdx(rfRdIdx), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx),
    .rfWrHiEn(rfWrHiEn), .rfWrLoEn(rfWrLoEn), .rfWrData(rfWrData),
    .doneOut(doneOut)
  );

  assign rfRdData = rfModel[rfRdIdx];

  always @(posedge clk) begin
    if (pokeEn) rfModel[pokeIdx] <= pokeVal;
    else if (rfWrEn) begin
      if (rfWrHiEn) rfModel[rfWrIdx][63:32] <= rfWrData[63:32];
      if (rfWrLoEn) rfModel[rfWrIdx][31:0]  <= rfWrData[31:0];
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expLoad(input logic [63:0] old, input bit dbl,
      input bit isInt, input bit be0, input bit be1,
      input logic [31:0] w0, input logic [31:0] w1);
    logic [63:0] r = old;
    if (!dbl) begin
      if (isInt) r = {{32{w0[31]}}, w0};
      else       r[63:32] = w0;
    end else begin
      if (be0) r[63:32] = w0; else r[31:0] = w0;
      if (be1) r[31:0]  = w1; else r[63:32] = w1;
    end
    return r;
  endfunction

  function automatic logic [31:0] expStore(input logic [63:0] v, input bit dbl,
      input bit isInt, input bit be, input bit second);
    if (!dbl) return isInt ? v[31:0] : v[63:32];
    return (be ^ second) ? v[63:32] : v[31:0];
  endfunction

  task automatic startXfer(input logic [3:0] idx, input bit st, input bit dbl,
                           input bit isInt);
    @(negedge clk);
    startIn = 1'b1; regIdx = idx; storeSel = st; sizeDouble = dbl;
    intView = isInt;
    @(negedge clk);
    startIn = 1'b0;
    regIdx = ~idx;  // R2: index input changes after capture
  endtask

  task automatic junkBeat();
    beatValid = 1'b1; beatIsData = 1'b0; dataIn = $urandom;
    #1;
    check(rfWrEn == 1'b0, "R10 non-data beat wrote", 64'(rfWrEn), 64'd0);
    @(negedge clk);
  endtask

  task automatic finishCheck(input string req);
    beatValid = 1'b0; beatIsData = 1'b0;
    check(doneOut == 1'b1, {req, " R11 done pulse"}, 64'(doneOut), 64'd1);
    @(negedge clk);
    check(doneOut == 1'b0, "R11 done one cycle", 64'(doneOut), 64'd0);
  endtask

  task automatic doLoad(input logic [3:0] idx, input bit dbl, input bit isInt,
      input bit be0, input bit be1, input logic [31:0] w0,
      input logic [31:0] w1, input bit junk, input bit busyStart, input string req);
    logic [63:0] old;
    logic [63:0] other;
    logic [63:0] exp;
    old = rfModel[idx];
    other = rfModel[idx ^ 4'h1];
    startXfer(idx, 1'b0, dbl, isInt);
    if (junk) junkBeat();
    beatValid = 1'b1; beatIsData = 1'b1; dataIn = w0; bigEnd = be0;
    if (busyStart) begin startIn = 1'b1; regIdx = idx ^ 4'h1; end
    @(negedge clk);
    startIn = 1'b0;
    if (dbl) begin
      check(doneOut == 1'b0, "R11 no done mid-transfer", 64'(doneOut), 64'd0);
      if (junk) junkBeat();
      beatValid = 1'b1; beatIsData = 1'b1; dataIn = w1; bigEnd = be1;
      @(negedge clk);
    end
    exp = expLoad(old, dbl, isInt, be0, be1, w0, w1);
    check(rfModel[idx] == exp, {req, " load result"}, rfModel[idx], exp);
    if (busyStart) begin
      finishCheck(req);
      // A second start, had it been taken, would now be waiting for beats.
      beatValid = 1'b1; beatIsData = 1'b1; dataIn = ~w0;
      #1;
      check(rfWrEn == 1'b0, "R12 start while busy was taken", 64'(rfWrEn), 64'd0);
      @(negedge clk);
      beatValid = 1'b0;
      check(rfModel[idx ^ 4'h1] == other, "R12 other register touched",
            rfModel[idx ^ 4'h1], other);
    end else begin
      finishCheck(req);
    end
  endtask

  task automatic doStore(input logic [3:0] idx, input bit dbl, input bit isInt,
      input bit be0, input bit be1, input logic [63:0] val, input string req);
    logic [31:0] exp;
    @(negedge clk);
    pokeEn = 1'b1; pokeIdx = idx; pokeVal = val;
    @(negedge clk);
    pokeEn = 1'b0;
    startXfer(idx, 1'b1, dbl, isInt);
    beatValid = 1'b1; beatIsData = 1'b1; bigEnd = be0; dataIn = $urandom;
    #1;
    exp = expStore(val, dbl, isInt, be0, 1'b0);
    check(dataOut == exp, {req, " store word 0"}, 64'(dataOut), 64'(exp));
    check(rfWrEn == 1'b0, {req, " store wrote register"}, 64'(rfWrEn), 64'd0);
    @(negedge clk);
    if (dbl) begin
      bigEnd = be1;
      #1;
      exp = expStore(val, dbl, isInt, be1, 1'b1);
      check(dataOut == exp, {req, " store word 1"}, 64'(dataOut), 64'(exp));
      @(negedge clk);
    end
    check(rfModel[idx] == val, {req, " register kept"}, rfModel[idx], val);
    finishCheck(req);
  endtask

  // Watchdog.
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 16; i++) rfModel[i] = 64'h0;
    rstN = 1'b0; startIn = 1'b0; regIdx = '0; storeSel = 1'b0;
    sizeDouble = 1'b0; intView = 1'b0; bigEnd = 1'b0;
    beatValid = 1'b1; beatIsData = 1'b1; dataIn = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    check(doneOut == 1'b0, "R1 done in reset", 64'(doneOut), 64'd0);
    check(rfWrEn == 1'b0, "R1 write in reset", 64'(rfWrEn), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(rfWrEn == 1'b0, "R1 idle write", 64'(rfWrEn), 64'd0);
    check(doneOut == 1'b0, "R1 idle done", 64'(doneOut), 64'd0);
    beatValid = 1'b0;

    // Directed corner cases.
    doLoad(4'd3, 1, 0, 1, 1, 32'h1111_2222, 32'h3333_4444, 0, 0, "R3 BE double");
    doLoad(4'd12, 1, 1, 0, 0, 32'hAAAA_0001, 32'hBBBB_0002, 0, 0, "R4 LE double");
    doLoad(4'd5, 1, 0, 1, 0, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 0, 0, "R5 endian flip");
    doLoad(4'd6, 1, 0, 0, 1, 32'h1234_5678, 32'h9ABC_DEF0, 0, 0, "R5 endian flip rev");
    doLoad(4'd3, 0, 0, 1, 1, 32'h7777_8888, 32'h0, 0, 0, "R6 float load");
    doLoad(4'd7, 0, 1, 0, 0, 32'h8000_0005, 32'h0, 0, 0, "R7 negative int");
    doLoad(4'd7, 0, 1, 1, 1, 32'h0000_0042, 32'h0, 0, 0, "R7 positive int");
    doLoad(4'd8, 1, 1, 1, 1, 32'hCAFE_0000, 32'h0000_BABE, 0, 0, "R11 restart after single");
    doLoad(4'd9, 1, 0, 0, 0, 32'h5555_6666, 32'h7777_9999, 1, 0, "R10 junk beats");
    doLoad(4'd10, 1, 0, 1, 1, 32'h0101_0101, 32'h0202_0202, 0, 1, "R12 busy start");
    doLoad(4'd11, 0, 1, 1, 1, 32'hFFFF_FFFE, 32'h0, 1, 1, "R2 index held");
    doStore(4'd2, 1, 0, 1, 1, 64'h0123_4567_89AB_CDEF, "R8 BE store");
    doStore(4'd4, 1, 1, 0, 0, 64'hFEDC_BA98_7654_3210, "R8 LE store");
    doStore(4'd13, 1, 0, 1, 0, 64'hAAAA_5555_CCCC_3333, "R8 flip store");
    doStore(4'd14, 0, 0, 0, 0, 64'h4049_0FDB_1111_1111, "R9 float store");
    doStore(4'd15, 0, 1, 1, 1, 64'h2222_2222_8000_0001, "R9 int store");

    // Constrained random mix.
    for (int n = 0; n < 80; n++) begin
      logic [3:0] idx;
      bit dbl, isInt, be0, be1, st, junk;
      idx = 4'($urandom); dbl = 1'($urandom); isInt = 1'($urandom);
      be0 = 1'($urandom); be1 = ($urandom % 4 == 0) ? ~be0 : be0;
      st = 1'($urandom); junk = ($urandom % 3 == 0);
      if (st) doStore(idx, dbl, isInt, be0, be1, {$urandom, $urandom}, "R8 R9 random store");
      else doLoad(idx, dbl, isInt, be0, be1, $urandom, $urandom, junk, 1'($urandom),
                  "R3 R4 R5 R6 R7 random load");
    end

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule